// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block is the command front end of an on-chip flash array. The CPU issues every command as a sequence of byte writes on a small write bus. Program and block erase each take two writes. The first write carries the command code. The second write carries the confirm code or the data to program, together with the target address. The sequencer checks the address and the protection inputs on the second write. When the operation is allowed, it launches it on a behavioural array port. It then holds a ready flag low until the array reports that the operation has finished, and whether verify passed.

Results are reported in two sticky error bits. A program failure sets only the program bit. An erase failure sets only the erase bit. A malformed sequence sets both bits. An explicit clear pulse is the only way to drop them. Writing FFh returns the block to read-array mode. As a first write it acts at once. As the second write of a command it cancels the pending command silently. A separate output shows whether the block is in read-array mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous reset, `array_read` is 1, `ready` is 1, `err_erase` and `err_prog` are 0 and `arr_start` is 0.
- R2: A first write of FFh enters read-array mode (`array_read`=1). FFh written as the second write of a program (first code 40h) or a block erase (first code 20h) also enters read-array mode. In that case the pending command is discarded, no error bit changes and `arr_start` stays 0. Any other accepted first write clears `array_read`.
- R3: The write pair 20h, D0h at an allowed address starts a block erase. In the cycle after the D0h write, `arr_start` is 1 and `arr_op` is 1 (erase), and `arr_addr` holds the second-write address.
- R4: A first write of 40h followed by a data byte other than FFh at an allowed address starts a program. In the cycle after the data write, `arr_start` is 1 and `arr_op` is 0, and `arr_addr` and `arr_wdata` hold the second-write address and data.
- R5: A sequence error sets both `err_erase` and `err_prog`, starts nothing, and is visible in the cycle after the offending write. A sequence error is either of two cases. The first is a second erase write other than D0h or FFh. The second is a first write other than 20h, 40h or FFh.
- R6: An address is allowed only when all three of these hold: `rewrite_en` is 1, the address is below FLASH_BYTES, and the lock bit of its block is 0. Block k covers addresses k*BLK_BYTES to (k+1)*BLK_BYTES-1 and is locked by `blk_lock[k]`. A disallowed erase sets only `err_erase`. A disallowed program sets only `err_prog`. In both cases `arr_start` stays 0.
- R7: If `arr_done` arrives with `arr_pass`=0, a failed erase sets only `err_erase` and a failed program sets only `err_prog`.
- R8: `ready` is 0 from the cycle of `arr_start` until the cycle after `arr_done`. Writes made while `ready` is 0 are ignored.
- R9: The error bits are sticky. They are cleared only by `clr_status`, and later successful commands leave them unchanged. If an error is raised in the same cycle as `clr_status`, the error bit ends up set.
- R10: `arr_start` is a single-cycle pulse for each launched operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | AW | CPU write address |
| wr_data | input | 8 | CPU write data (command code, confirm code or program data) |
| rewrite_en | input | 1 | Global rewrite enable |
| blk_lock | input | NBLK | Per-block rewrite disable |
| clr_status | input | 1 | Pulse that clears both error bits |
| arr_done | input | 1 | Array reports the operation has finished |
| arr_pass | input | 1 | Verify result, valid with arr_done |
| arr_start | output | 1 | One-cycle launch strobe to the array |
| arr_op | output | 1 | Operation to launch: 1 erase, 0 program |
| arr_addr | output | AW | Target address of the launched operation |
| arr_wdata | output | 8 | Byte to program |
| ready | output | 1 | 1 when no array operation is in progress |
| array_read | output | 1 | 1 in read-array mode |
| err_erase | output | 1 | Erase error bit (also set on a sequence error) |
| err_prog | output | 1 | Program error bit (also set on a sequence error) |

## Verification
The bench aims at the silent cancel, an FFh second write on both program and erase. A design that treated FFh like any other confirm value would raise a sequence error or launch an operation. It also targets addresses just past the allocated range and inside locked blocks. A design whose guard is wrong would start the array or set the wrong one of the two bits. Writes made while an operation is in progress are checked by following them with an erase. A sequencer that had accepted the busy write would launch that erase as a program. A sequence error raised in the same cycle as a clear pulse shows whether the clear wrongly wins.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [7:0] CODE_PROG  = 8'h40;
  localparam logic [7:0] CODE_ERASE = 8'h20;
  localparam logic [7:0] CODE_READ  = 8'hFF;
  localparam logic [7:0] CODE_CONF  = 8'hD0;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PROG  = 2'd1,
    SQ_ERASE = 2'd2,
    SQ_BUSY  = 2'd3
  } sq_state_t;
endpackage

// File: rtl/fcs_guard.sv
module fcs_guard #(
  parameter int AW          = 16,
  parameter int FLASH_BYTES = 32768,
  parameter int BLK_BYTES   = 8192,
  localparam int NBLK       = FLASH_BYTES / BLK_BYTES
) (
  input  logic [AW-1:0]   addr,
  input  logic            rewrite_en,
  input  logic [NBLK-1:0] blk_lock,
  output logic            allowed
);
  logic [31:0]     addr32;
  logic [NBLK-1:0] in_blk;

  assign addr32 = 32'(addr);

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    assign in_blk[g] = (addr32 >= 32'(g * BLK_BYTES)) &&
                       (addr32 <  32'((g + 1) * BLK_BYTES));
  end

  // an unallocated address hits no block and is therefore rejected
  assign allowed = rewrite_en && |(in_blk & ~blk_lock);
endmodule

// File: rtl/fcs_status.sv
module fcs_status (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set_erase,
  input  logic set_prog,
  output logic err_erase,
  output logic err_prog
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
    end else begin
      err_erase <= (err_erase & ~clr) | set_erase;
      err_prog  <= (err_prog  & ~clr) | set_prog;
    end
  end

  // R9
  erase_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_erase) |-> $past(clr));
  // R9
  prog_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_prog) |-> $past(clr));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW          = 16,
  parameter int FLASH_BYTES = 32768,
  parameter int BLK_BYTES   = 8192,
  localparam int NBLK       = FLASH_BYTES / BLK_BYTES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            rewrite_en,
  input  logic [NBLK-1:0] blk_lock,
  input  logic            clr_status,
  input  logic            arr_done,
  input  logic            arr_pass,
  output logic            arr_start,
  output logic            arr_op,
  output logic [AW-1:0]   arr_addr,
  output logic [7:0]      arr_wdata,
  output logic            ready,
  output logic            array_read,
  output logic            err_erase,
  output logic            err_prog
);
  import fcs_pkg::*;

  sq_state_t state, state_n;
  logic      allowed;
  logic      mode_n, launch, launch_op;
  logic      seq_err, bad_erase, bad_prog;

  fcs_guard #(.AW(AW), .FLASH_BYTES(FLASH_BYTES), .BLK_BYTES(BLK_BYTES)) u_guard (
    .addr       (wr_addr),
    .rewrite_en (rewrite_en),
    .blk_lock   (blk_lock),
    .allowed    (allowed)
  );

  always_comb begin
    state_n   = state;
    mode_n    = array_read;
    launch    = 1'b0;
    launch_op = 1'b0;
    seq_err   = 1'b0;
    bad_erase = 1'b0;
    bad_prog  = 1'b0;
    unique case (state)
      SQ_IDLE: if (wr_en) begin
        mode_n = 1'b0;
        if (wr_data == CODE_READ)       mode_n  = 1'b1;
        else if (wr_data == CODE_PROG)  state_n = SQ_PROG;
        else if (wr_data == CODE_ERASE) state_n = SQ_ERASE;
        else                            seq_err = 1'b1;
      end
      SQ_PROG: if (wr_en) begin
        state_n = SQ_IDLE;
        if (wr_data == CODE_READ) mode_n = 1'b1;
        else if (allowed) begin
          launch  = 1'b1;
          state_n = SQ_BUSY;
        end else bad_prog = 1'b1;
      end
      SQ_ERASE: if (wr_en) begin
        state_n = SQ_IDLE;
        if (wr_data == CODE_READ) mode_n = 1'b1;
        else if (wr_data == CODE_CONF) begin
          if (allowed) begin
            launch    = 1'b1;
            launch_op = 1'b1;
            state_n   = SQ_BUSY;
          end else bad_erase = 1'b1;
        end else seq_err = 1'b1;
      end
      SQ_BUSY: if (arr_done) begin
        state_n = SQ_IDLE;
        if (!arr_pass) begin
          bad_erase = arr_op;
          bad_prog  = ~arr_op;
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      array_read <= 1'b1;
      ready      <= 1'b1;
      arr_start  <= 1'b0;
      arr_op     <= 1'b0;
      arr_addr   <= '0;
      arr_wdata  <= '0;
    end else begin
      state      <= state_n;
      array_read <= mode_n;
      ready      <= (state_n != SQ_BUSY);
      arr_start  <= launch;
      if (launch) begin
        arr_op    <= launch_op;
        arr_addr  <= wr_addr;
        arr_wdata <= wr_data;
      end
    end
  end

  fcs_status u_status (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_status),
    .set_erase (seq_err | bad_erase),
    .set_prog  (seq_err | bad_prog),
    .err_erase (err_erase),
    .err_prog  (err_prog)
  );

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    arr_start |=> !arr_start);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_start |-> !ready);
  // R8
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(arr_done));
  // R6
  start_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    arr_start |-> (32'(arr_addr) < 32'(FLASH_BYTES)));
endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int AW = 16, FLASH = 32768, BLK = 8192, NB = FLASH / BLK;

  logic clk = 0, rst = 1, wr_en = 0, rewrite_en = 1, clr_status = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NB-1:0] blk_lock = '0;
  logic arr_done = 0, arr_pass = 1;
  logic arr_start, arr_op, ready, array_read, err_erase, err_prog;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata;

  int errors = 0, checks = 0, lat = 0, resp_lat = 3;
  logic pass_cfg = 1;
  logic exp_e = 0, exp_p = 0, exp_rm = 1;

  flash_cmd_seq #(.AW(AW), .FLASH_BYTES(FLASH), .BLK_BYTES(BLK)) uut (.*);

  always #2 clk = ~clk;

  // behavioural array: completes resp_lat cycles after a launch
  always @(posedge clk) begin
    if (rst) begin
      lat <= 0; arr_done <= 0;
    end else begin
      arr_done <= 0;
      if (arr_start) lat <= resp_lat;
      else if (lat != 0) begin
        if (lat == 1) begin arr_done <= 1; arr_pass <= pass_cfg; end
        lat <= lat - 1;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 60 && !ready; i++) @(negedge clk);
  endtask

  function automatic logic addr_ok(logic [AW-1:0] a);
    if (int'(a) >= FLASH) return 0;
    return rewrite_en && !blk_lock[int'(a) / BLK];
  endfunction

  task automatic check_status(string req);
    check({req, " err bits"}, {err_erase, err_prog}, {exp_e, exp_p});
    check({req, " mode"}, array_read, exp_rm);
  endtask

  // two-write program (is_erase=0) or erase (is_erase=1) with model
  task automatic run_cmd(logic is_erase, logic [7:0] d2, logic [AW-1:0] a, logic pass);
    logic go;
    pass_cfg = pass;
    go = 0;
    bus_write('0, is_erase ? 8'h20 : 8'h40);
    exp_rm = 0;
    bus_write(a, d2);
    if (d2 == 8'hFF) exp_rm = 1;                        // R2
    else if (is_erase && d2 != 8'hD0) begin exp_e = 1; exp_p = 1; end  // R5
    else if (!addr_ok(a)) begin                         // R6
      if (is_erase) exp_e = 1; else exp_p = 1;
    end else go = 1;
    check(is_erase ? "R3 start" : "R4 start", arr_start, go);
    if (go) begin
      check("R8 busy", ready, 0);
      check(is_erase ? "R3 op" : "R4 op", arr_op, is_erase);
      check("R4 addr", arr_addr, a);
      if (!is_erase) check("R4 data", arr_wdata, d2);
      @(negedge clk);
      check("R10 pulse", arr_start, 0);
      wait_ready();
      if (!pass) begin if (is_erase) exp_e = 1; else exp_p = 1; end  // R7
    end
    check_status(is_erase ? "R3/R5/R6/R7 erase" : "R4/R6/R7 prog");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] c;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check("R1 ready", ready, 1);
    check("R1 start", arr_start, 0);
    check_status("R1");

    // directed corners
    run_cmd(0, 8'hFF, 16'h0100, 1);   // R2 cancel program
    run_cmd(1, 8'hFF, 16'h0100, 1);   // R2 cancel erase
    run_cmd(1, 8'hD0, 16'h2000, 1);   // R3 ok erase
    run_cmd(0, 8'h5A, 16'h7FFF, 1);   // R4 last allocated byte
    run_cmd(0, 8'h5A, 16'h8000, 1);   // R6 first unallocated byte
    check("R6 prog only", {err_erase, err_prog}, 2'b01);
    @(negedge clk); clr_status = 1; @(negedge clk); clr_status = 0;
    exp_e = 0; exp_p = 0;
    check_status("R9 clear");
    blk_lock = 4'b0100;
    run_cmd(1, 8'hD0, 16'h4123, 1);   // R6 locked block erase
    check("R6 erase only", {err_erase, err_prog}, 2'b10);
    blk_lock = 0;
    run_cmd(0, 8'h33, 16'h0010, 1);   // R9 success leaves bits
    check("R9 sticky", err_erase, 1);
    run_cmd(1, 8'h12, 16'h0010, 1);   // R5 bad confirm
    // R9 error raised with clear in same cycle
    @(negedge clk); wr_en = 1; wr_data = 8'h77; clr_status = 1;
    @(negedge clk); wr_en = 0; clr_status = 0;
    exp_e = 1; exp_p = 1; exp_rm = 0;
    check_status("R9 set wins R5");
    @(negedge clk); clr_status = 1; @(negedge clk); clr_status = 0;
    exp_e = 0; exp_p = 0;
    bus_write('0, 8'hFF); exp_rm = 1;
    check_status("R2 first-write read");
    run_cmd(0, 8'h99, 16'h1000, 0);   // R7 program verify fail
    @(negedge clk); clr_status = 1; @(negedge clk); clr_status = 0;
    exp_e = 0; exp_p = 0;
    // R8 write during busy is ignored
    resp_lat = 10; pass_cfg = 1;
    bus_write('0, 8'h40);
    bus_write(16'h0200, 8'h11);
    check("R8 launched", arr_start, 1);
    bus_write('0, 8'h40);
    check("R8 still busy", ready, 0);
    wait_ready();
    resp_lat = 3;
    run_cmd(1, 8'hD0, 16'h0300, 1);   // must launch as erase (R8)
    check_status("R8 after busy");

    // constrained random
    for (int n = 0; n < 300; n++) begin
      int k;
      logic [AW-1:0] a;
      logic [7:0] d;
      k = $urandom % 8;
      a = AW'($urandom % 40000);
      rewrite_en = ($urandom % 4) != 0;
      blk_lock = NB'($urandom % 16) & NB'($urandom % 16);
      resp_lat = 1 + ($urandom % 4);
      if ($urandom % 6 == 0) begin
        @(negedge clk); clr_status = 1; @(negedge clk); clr_status = 0;
        exp_e = 0; exp_p = 0;
        check_status("R9 clear rnd");
      end
      if (k < 3) begin
        d = ($urandom % 6 == 0) ? 8'hFF : 8'($urandom);
        run_cmd(0, d, a, ($urandom % 4) != 0);
      end else if (k < 6) begin
        case ($urandom % 4)
          0: d = 8'hFF;
          3: d = 8'($urandom);
          default: d = 8'hD0;
        endcase
        run_cmd(1, d, a, ($urandom % 4) != 0);
      end else if (k == 6) begin
        c = 8'($urandom);
        if (c == 8'h20 || c == 8'h40 || c == 8'hFF) c = 8'h11;
        bus_write('0, c);
        exp_e = 1; exp_p = 1; exp_rm = 0;
        check_status("R5 bad code");
      end else begin
        bus_write('0, 8'hFF);
        exp_rm = 1;
        check_status("R2 read rnd");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule